// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block is the control engine of a register-mapped I2C master. Software loads a 7-bit target address and, for writes, up to four data bytes into a small buffer. It then writes the control register to start a transfer of one to four bytes. The engine steps through the bus phases one command at a time: start with the address and direction byte, each data byte, and stop. It drives them through a byte-level command handshake, and the bus side reports acknowledge results. SCL/SDA bit timing, 10-bit addressing and slave operation lie outside the block.

The engine does not always release the bus between bytes. Chaining keeps the bus held across bytes and across transfers, and a repeated-start request forces a stop after each byte. A halt command releases a bus that is still held. A negative acknowledge aborts the sequence and sets error flags. On every completion the count register records how many bytes actually moved. An interrupt line can be raised on completion or on halt, and it needs both the global enable and a per-event mask bit.

Register offsets: 0 data buffer, 1 target address, 2 control, 3 mode, 4 status, 5 extended status, 6 interrupt mask, 7 transfer count, 8 extended control. Bus commands on `bus_cmd`: 0 start+address, 1 send byte, 2 receive byte, 3 stop.

Top module: `i2c_xfer_seq`

## Requirements
- R1: Control (offset 2): bit 0 starts a transfer and always reads back 0. Bit 1 selects read, bit 2 chaining, bit 3 repeated start, bits 5:4 hold byte count minus one, and bit 7 is halt. All other written bits read back as written.
- R2: A start phase (cmd 0) is issued only when the bus is free. It sends {target address bits 7:1, read bit}, taken from offset 1. Each data byte then uses cmd 1 (send) or cmd 2 (receive).
- R3: A stop (cmd 3) follows each byte when repeated start is set or chaining is clear. Otherwise the bus stays held, and the next byte or transfer skips the start phase.
- R4: A negative acknowledge on the address or a data byte aborts the transfer. It sets status bit 2 and extended-status bit 0. A transfer that completes without a negative acknowledge clears status bit 2.
- R5: On completion the count register (offset 7) holds the number of bytes moved. Send bytes leave the buffer (offset 0) in push order. Received bytes are read back from offset 0 in arrival order, and a read of the empty buffer returns 0xFF.
- R6: When at least one byte has moved, mode bit 2 and mask (offset 6) bit 0 together set status bit 1 and assert `irq`. With either bit clear, or with zero bytes moved, `irq` stays low.
- R7: Control bit 7 written while the bus is held issues a stop. If mode bit 2 and mask bit 3 are both set, this raises `irq` and status bit 1.
- R8: Writing a one to status bit 1 clears it, and if mode bit 2 is set, it also deasserts `irq`.
- R9: Extended status (offset 5) reads 0x40 with the bus free and 0x50 with the bus held, ORed with its error bit 0. Writing a one to bit 0 clears that error bit.
- R10: Mode (offset 3) keeps only the bits of mask 0x3D, and a write with bit 6 set empties the data buffer. Count writes keep only the bits of mask 0x77.
- R11: Writing bit 0 of extended control (offset 8) clears the control, mode, status, mask, count and buffer registers and drops `irq`. The target address is kept.
- R12: `bus_req` stays high with a stable `bus_cmd` until `bus_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | AW | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data, valid the cycle after `reg_re` |
| bus_req | output | 1 | Bus command request |
| bus_cmd | output | 2 | Command: 0 start, 1 send, 2 receive, 3 stop |
| bus_wdata | output | 8 | Address byte or data byte to send |
| bus_done | input | 1 | Command finished (one-cycle pulse) |
| bus_ack | input | 1 | Command acknowledged |
| bus_rdata | input | 8 | Received byte, valid with `bus_done` |
| irq | output | 1 | Interrupt line |

## Verification
The assertions check several properties on every cycle:
- the command handshake holds steady until `bus_done`;
- a start never goes out on a held bus, and a stop never goes out on a free one;
- control bit 0 always reads back as 0, and extended status always reads one of its two bus-state codes;
- the mode write mask applies;
- `irq` never rises without the global enable.

Only the bench scenarios can show the rest: the exact phase sequence for each combination of chaining and repeated start, byte counts after an abort part-way through a transfer, the ordering of data through the buffer, interrupt gating by each mask bit, halt behaviour, and what a soft reset keeps.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int BYTE_W = 8;

  localparam int REG_DATA  = 0;
  localparam int REG_TADDR = 1;
  localparam int REG_CTRL  = 2;
  localparam int REG_MODE  = 3;
  localparam int REG_STAT  = 4;
  localparam int REG_XSTAT = 5;
  localparam int REG_IMASK = 6;
  localparam int REG_XCNT  = 7;
  localparam int REG_XCTL  = 8;

  localparam logic [BYTE_W-1:0] MODE_KEEP = 8'h3D;
  localparam logic [BYTE_W-1:0] XCNT_KEEP = 8'h77;
  localparam logic [BYTE_W-1:0] XST_FREE  = 8'h40;
  localparam logic [BYTE_W-1:0] XST_HELD  = 8'h50;

  typedef enum logic [1:0] {
    CMD_START = 2'd0,
    CMD_SEND  = 2'd1,
    CMD_RECV  = 2'd2,
    CMD_STOP  = 2'd3
  } bus_cmd_e;

  typedef enum logic [2:0] {
    E_IDLE, E_CHK, E_START, E_BYTE, E_STOP, E_HALT, E_DONE
  } eng_state_e;
endpackage

// File: rtl/i2c_seq_databuf.sv
module i2c_seq_databuf
  import i2c_seq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [BYTE_W-1:0] push_dat_i,
  input  logic              pop_i,
  input  logic              ewr_i,
  input  logic [IDXW-1:0]   ewr_idx_i,
  input  logic [BYTE_W-1:0] ewr_dat_i,
  input  logic              setlvl_i,
  input  logic [CNTW-1:0]   setlvl_val_i,
  input  logic [IDXW-1:0]   rd_idx_i,
  output logic [BYTE_W-1:0] rd_dat_o,
  output logic [BYTE_W-1:0] front_o,
  output logic [CNTW-1:0]   level_o
);
  logic [BYTE_W-1:0] mem_q [DEPTH];
  logic [CNTW-1:0]   lvl_q;
  logic              can_push, can_pop;

  assign can_push = push_i && (lvl_q != CNTW'(DEPTH));
  assign can_pop  = pop_i && (lvl_q != '0);

  always_ff @(posedge clk) begin
    if (rst || flush_i) begin
      lvl_q <= '0;
    end else if (setlvl_i) begin
      lvl_q <= setlvl_val_i;
    end else if (can_push) begin
      lvl_q <= lvl_q + 1'b1;
    end else if (can_pop) begin
      lvl_q <= lvl_q - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || flush_i) begin
        mem_q[i] <= '0;
      end else if (ewr_i) begin
        if (ewr_idx_i == IDXW'(i)) mem_q[i] <= ewr_dat_i;
      end else if (can_push) begin
        if (lvl_q[IDXW-1:0] == IDXW'(i)) mem_q[i] <= push_dat_i;
      end else if (can_pop) begin
        if (i < DEPTH - 1) mem_q[i] <= mem_q[(i + 1) % DEPTH];
        else               mem_q[i] <= '0;
      end
    end
  end

  assign rd_dat_o = mem_q[rd_idx_i];
  assign front_o  = mem_q[0];
  assign level_o  = lvl_q;
endmodule

// File: rtl/i2c_seq_engine.sv
module i2c_seq_engine
  import i2c_seq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int IDXW = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              halt_i,
  input  logic              recv_i,
  input  logic              chain_i,
  input  logic              rpst_i,
  input  logic [IDXW-1:0]   last_i,
  input  logic [6:0]        addr7_i,
  output logic [IDXW-1:0]   buf_idx_o,
  input  logic [BYTE_W-1:0] buf_dat_i,
  output logic              buf_wr_o,
  output logic [BYTE_W-1:0] buf_wdat_o,
  output logic              bus_req_o,
  output logic [1:0]        bus_cmd_o,
  output logic [BYTE_W-1:0] bus_wdata_o,
  input  logic              bus_done_i,
  input  logic              bus_ack_i,
  input  logic [BYTE_W-1:0] bus_rdata_i,
  output logic              held_o,
  output logic              run_o,
  output logic              done_o,
  output logic              halted_o,
  output logic              err_o,
  output logic [CNTW-1:0]   moved_o
);
  eng_state_e        st_q;
  logic [IDXW-1:0]   idx_q, last_q;
  logic [6:0]        addr_q;
  logic              recv_q, stop_each_q, held_q, err_q;
  logic [CNTW-1:0]   moved_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= E_IDLE;
      idx_q       <= '0;
      last_q      <= '0;
      addr_q      <= '0;
      recv_q      <= 1'b0;
      stop_each_q <= 1'b0;
      held_q      <= 1'b0;
      err_q       <= 1'b0;
      moved_q     <= '0;
    end else begin
      unique case (st_q)
        E_IDLE: begin
          if (halt_i && held_q) begin
            st_q <= E_HALT;
          end else if (start_i) begin
            idx_q       <= '0;
            last_q      <= last_i;
            addr_q      <= addr7_i;
            recv_q      <= recv_i;
            stop_each_q <= rpst_i || !chain_i;
            err_q       <= 1'b0;
            moved_q     <= '0;
            st_q        <= E_CHK;
          end
        end
        E_CHK: st_q <= held_q ? E_BYTE : E_START;
        E_START: if (bus_done_i) begin
          if (bus_ack_i) begin
            held_q <= 1'b1;
            st_q   <= E_BYTE;
          end else begin
            err_q <= 1'b1;
            st_q  <= E_DONE;
          end
        end
        E_BYTE: if (bus_done_i) begin
          if (bus_ack_i) begin
            moved_q <= moved_q + 1'b1;
            if (stop_each_q) begin
              st_q <= E_STOP;
            end else if (idx_q == last_q) begin
              st_q <= E_DONE;
            end else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= E_CHK;
            end
          end else begin
            err_q <= 1'b1;
            st_q  <= E_DONE;
          end
        end
        E_STOP: if (bus_done_i) begin
          held_q <= 1'b0;
          if (idx_q == last_q) begin
            st_q <= E_DONE;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= E_CHK;
          end
        end
        E_HALT: if (bus_done_i) begin
          held_q <= 1'b0;
          st_q   <= E_IDLE;
        end
        E_DONE: st_q <= E_IDLE;
        default: st_q <= E_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_req_o = 1'b0;
    bus_cmd_o = CMD_STOP;
    unique case (st_q)
      E_START: begin bus_req_o = 1'b1; bus_cmd_o = CMD_START; end
      E_BYTE:  begin bus_req_o = 1'b1; bus_cmd_o = recv_q ? CMD_RECV : CMD_SEND; end
      E_STOP, E_HALT: begin bus_req_o = 1'b1; bus_cmd_o = CMD_STOP; end
      default: ;
    endcase
  end

  assign bus_wdata_o = (st_q == E_START) ? {addr_q, recv_q} : buf_dat_i;
  assign buf_idx_o   = idx_q;
  assign buf_wr_o    = (st_q == E_BYTE) && bus_done_i && bus_ack_i && recv_q;
  assign buf_wdat_o  = bus_rdata_i;
  assign held_o      = held_q;
  assign run_o       = (st_q != E_IDLE);
  assign done_o      = (st_q == E_DONE);
  assign halted_o    = (st_q == E_HALT) && bus_done_i;
  assign err_o       = err_q;
  assign moved_o     = moved_q;
endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2c_seq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int AW    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [AW-1:0]     reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_done,
  input  logic              bus_ack,
  input  logic [BYTE_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int IDXW = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [BYTE_W-1:0] taddr_q, ctrl_q, mode_q, imask_q, xcnt_q, rdata_q;
  logic              sts_irqa_q, sts_err_q, xfra_q, irq_q;

  logic              eng_run, eng_held, eng_done, eng_halted, eng_err, buf_wr;
  logic [CNTW-1:0]   eng_moved, buf_lvl;
  logic [IDXW-1:0]   buf_idx;
  logic [BYTE_W-1:0] buf_rd, buf_front, buf_wdat;

  logic wr_data, wr_ctrl, wr_mode, wr_stat, wr_xstat, wr_imask, wr_xcnt;
  logic ctl_ok, halt_go, start_go, soft_rst, flush, pop;

  assign wr_data  = reg_we && reg_addr == AW'(REG_DATA);
  assign wr_ctrl  = reg_we && reg_addr == AW'(REG_CTRL);
  assign wr_mode  = reg_we && reg_addr == AW'(REG_MODE);
  assign wr_stat  = reg_we && reg_addr == AW'(REG_STAT);
  assign wr_xstat = reg_we && reg_addr == AW'(REG_XSTAT);
  assign wr_imask = reg_we && reg_addr == AW'(REG_IMASK);
  assign wr_xcnt  = reg_we && reg_addr == AW'(REG_XCNT);
  assign soft_rst = reg_we && reg_addr == AW'(REG_XCTL) && reg_wdata[0];

  // Control writes are taken only while the engine is idle.
  assign ctl_ok   = wr_ctrl && !eng_run;
  assign halt_go  = ctl_ok && reg_wdata[7] && eng_held;
  assign start_go = ctl_ok && !halt_go && reg_wdata[0];
  assign flush    = soft_rst || (wr_mode && reg_wdata[6]);
  assign pop      = reg_re && reg_addr == AW'(REG_DATA) && buf_lvl != '0;

  i2c_seq_databuf #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst(rst), .flush_i(flush),
    .push_i(wr_data), .push_dat_i(reg_wdata), .pop_i(pop),
    .ewr_i(buf_wr), .ewr_idx_i(buf_idx), .ewr_dat_i(buf_wdat),
    .setlvl_i(eng_done), .setlvl_val_i(eng_moved),
    .rd_idx_i(buf_idx), .rd_dat_o(buf_rd), .front_o(buf_front),
    .level_o(buf_lvl)
  );

  i2c_seq_engine #(.DEPTH(DEPTH)) u_eng (
    .clk(clk), .rst(rst), .start_i(start_go), .halt_i(halt_go),
    .recv_i(reg_wdata[1]), .chain_i(reg_wdata[2]), .rpst_i(reg_wdata[3]),
    .last_i(reg_wdata[4 +: IDXW]), .addr7_i(taddr_q[7:1]),
    .buf_idx_o(buf_idx), .buf_dat_i(buf_rd),
    .buf_wr_o(buf_wr), .buf_wdat_o(buf_wdat),
    .bus_req_o(bus_req), .bus_cmd_o(bus_cmd), .bus_wdata_o(bus_wdata),
    .bus_done_i(bus_done), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
    .held_o(eng_held), .run_o(eng_run), .done_o(eng_done),
    .halted_o(eng_halted), .err_o(eng_err), .moved_o(eng_moved)
  );

  // Target address survives the soft reset.
  always_ff @(posedge clk) begin
    if (rst) taddr_q <= '0;
    else if (reg_we && reg_addr == AW'(REG_TADDR)) taddr_q <= reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      ctrl_q     <= '0;
      mode_q     <= '0;
      imask_q    <= '0;
      xcnt_q     <= '0;
      sts_irqa_q <= 1'b0;
      sts_err_q  <= 1'b0;
      xfra_q     <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (ctl_ok)   ctrl_q  <= reg_wdata & 8'hFE;
      if (wr_mode)  mode_q  <= reg_wdata & MODE_KEEP;
      if (wr_imask) imask_q <= reg_wdata;
      if (wr_xcnt)  xcnt_q  <= reg_wdata & XCNT_KEEP;
      if (wr_stat && reg_wdata[1]) begin
        sts_irqa_q <= 1'b0;
        if (mode_q[2]) irq_q <= 1'b0;
      end
      if (wr_xstat && reg_wdata[0]) xfra_q <= 1'b0;
      if (eng_done) begin
        xcnt_q    <= BYTE_W'(eng_moved);
        sts_err_q <= eng_err;
        if (eng_err) xfra_q <= 1'b1;
        if (eng_moved != '0 && mode_q[2] && imask_q[0]) begin
          sts_irqa_q <= 1'b1;
          irq_q      <= 1'b1;
        end
      end
      if (eng_halted && mode_q[2] && imask_q[3]) begin
        sts_irqa_q <= 1'b1;
        irq_q      <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (reg_re) begin
      unique case (int'(reg_addr))
        REG_DATA:  rdata_q <= (buf_lvl == '0) ? 8'hFF : buf_front;
        REG_TADDR: rdata_q <= taddr_q;
        REG_CTRL:  rdata_q <= ctrl_q;
        REG_MODE:  rdata_q <= mode_q;
        REG_STAT:  rdata_q <= {2'b00, buf_lvl != '0, buf_lvl == CNTW'(DEPTH),
                               1'b0, sts_err_q, sts_irqa_q, eng_run};
        REG_XSTAT: rdata_q <= (eng_held ? XST_HELD : XST_FREE) | {7'd0, xfra_q};
        REG_IMASK: rdata_q <= imask_q;
        REG_XCNT:  rdata_q <= xcnt_q;
        default:   rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign irq       = irq_q;
endmodule

// File: rtl/i2c_xfer_seq_chk.sv
module i2c_xfer_seq_chk
  import i2c_seq_pkg::*;
#(
  parameter int AW = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic              reg_re,
  input logic [AW-1:0]     reg_addr,
  input logic [BYTE_W-1:0] reg_wdata,
  input logic [BYTE_W-1:0] reg_rdata,
  input logic              bus_req,
  input logic [1:0]        bus_cmd,
  input logic              bus_done,
  input logic              irq,
  input logic [BYTE_W-1:0] mode_q,
  input logic              eng_held
);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_done |=> bus_req && $stable(bus_cmd));

  assert_start_free_R2: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_cmd == CMD_START |-> !eng_held);

  assert_stop_held_R3: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_cmd == CMD_STOP |-> eng_held);

  assert_ctrl_rd0_R1: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && reg_re && reg_addr == AW'(REG_CTRL)) |-> reg_rdata[0] == 1'b0);

  assert_xstat_code_R9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && reg_re && reg_addr == AW'(REG_XSTAT)) |->
      (reg_rdata[7:1] == 7'h20 || reg_rdata[7:1] == 7'h28));

  assert_irq_enable_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(mode_q[2]));

  assert_mode_mask_R10: assert property (@(posedge clk) disable iff (rst)
    reg_we && reg_addr == AW'(REG_MODE) |=> mode_q == ($past(reg_wdata) & MODE_KEEP));
endmodule

bind i2c_xfer_seq i2c_xfer_seq_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
  .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_done(bus_done),
  .irq(irq), .mode_q(mode_q), .eng_held(eng_held)
);

// File: tb/i2c_xfer_seq_tb.sv
`timescale 1ns/1ps
module i2c_xfer_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_we = 1'b0, reg_re = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       bus_req;
  logic [1:0] bus_cmd;
  logic [7:0] bus_wdata;
  logic       bus_done = 1'b0, bus_ack = 1'b0;
  logic [7:0] bus_rdata = '0;
  logic       irq;

  always #4 clk = ~clk;

  i2c_xfer_seq dut_i (.*);

  int total = 0, bad = 0;
  bit fin = 0;

  // Bus model: answers each request one cycle later, logs every command.
  logic [1:0] ev_cmd [64];
  logic [7:0] ev_dat [64];
  int ev_n = 0, byte_i = 0, rx_cnt = 0, nack_at = 15;
  logic [6:0] dev_addr = 7'h2A;

  always @(posedge clk) begin
    if (rst) begin
      bus_done <= 1'b0;
    end else begin
      bus_done <= 1'b0;
      if (bus_req && !bus_done) begin
        bus_done <= 1'b1;
        if (ev_n < 64) begin ev_cmd[ev_n] = bus_cmd; ev_dat[ev_n] = bus_wdata; end
        ev_n++;
        case (bus_cmd)
          2'd0: bus_ack <= (bus_wdata[7:1] == dev_addr);
          2'd1: begin bus_ack <= (byte_i != nack_at); byte_i++; end
          2'd2: begin bus_ack <= 1'b1; bus_rdata <= 8'hA0 + 8'(rx_cnt); rx_cnt++; byte_i++; end
          default: bus_ack <= 1'b1;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=0x%0h expected=0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); reg_we = 1'b1; reg_addr = 4'(a); reg_wdata = 8'(d);
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk); reg_re = 1'b1; reg_addr = 4'(a);
    @(negedge clk); reg_re = 1'b0; d = int'(reg_rdata);
  endtask

  task automatic wait_idle();
    int s;
    for (int k = 0; k < 200; k++) begin
      rd(4, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  task automatic clr_log();
    ev_n = 0; byte_i = 0; rx_cnt = 0;
  endtask

  typedef struct packed {
    logic [7:0] ctrl;
    logic [3:0] nack;
    logic       aok;
    logic [2:0] ecnt;
    logic       eerr;
    logic [4:0] eev;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{8'h01, 4'hF, 1'b1, 3'd1, 1'b0, 5'd3},   // write 1, stop each
    '{8'h31, 4'hF, 1'b1, 3'd4, 1'b0, 5'd12},  // write 4, stop each
    '{8'h17, 4'hF, 1'b1, 3'd2, 1'b0, 5'd3},   // read 2 chained
    '{8'h2F, 4'hF, 1'b1, 3'd3, 1'b0, 5'd9},   // read 3 chained + repeated start
    '{8'h21, 4'd1, 1'b1, 3'd1, 1'b1, 5'd5},   // write 3, nack on 2nd byte
    '{8'h11, 4'hF, 1'b0, 3'd0, 1'b1, 5'd1},   // address nack
    '{8'h15, 4'hF, 1'b1, 3'd2, 1'b0, 5'd3}    // write 2 chained
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog: got=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // Reset state
    rd(2, v); chk("R1 reset ctrl", v, 0);
    rd(3, v); chk("R10 reset mode", v, 0);
    rd(4, v); chk("R4 reset status", v, 0);
    rd(5, v); chk("R9 reset xstat free", v, 8'h40);
    rd(7, v); chk("R5 reset count", v, 0);
    chk("R6 reset irq", int'(irq), 0);

    wr(1, 8'h54);

    // Table walk
    foreach (VEC[i]) begin
      wr(3, 8'h40);
      wr(0, 8'h11); wr(0, 8'h22); wr(0, 8'h33); wr(0, 8'h44);
      dev_addr = VEC[i].aok ? 7'h2A : 7'h7F;
      nack_at  = int'(VEC[i].nack);
      clr_log();
      wr(2, VEC[i].ctrl);
      wait_idle();
      rd(7, v); chk($sformatf("R5 vec%0d count", i), v, int'(VEC[i].ecnt));
      rd(4, v); chk($sformatf("R4 vec%0d err", i), (v >> 2) & 1, int'(VEC[i].eerr));
      chk($sformatf("R3 vec%0d phases", i), ev_n, int'(VEC[i].eev));
      if (i == 1) begin
        chk("R5 send order b0", int'(ev_dat[1]), 8'h11);
        chk("R5 send order b3", int'(ev_dat[10]), 8'h44);
        chk("R3 stop after byte", int'(ev_cmd[2]), 3);
      end
      if (i == 2) begin
        chk("R2 read addr byte", int'(ev_dat[0]), 8'h55);
        chk("R2 recv cmd", int'(ev_cmd[1]), 2);
        rd(5, v); chk("R3 R9 chained held", v, 8'h50);
      end
      if (i == 5) begin
        rd(5, v); chk("R4 R9 xstat err", v, 8'h41);
        wr(5, 8'h01);
        rd(5, v); chk("R9 err clear", v, 8'h40);
      end
      rd(5, v);
      if (v[4]) begin wr(2, 8'h80); wait_idle(); end
      wr(5, 8'h01);
    end

    // Chained bus held: next transfer skips start
    wr(3, 8'h40); wr(0, 8'h5A); clr_log(); nack_at = 15; dev_addr = 7'h2A;
    wr(2, 8'h05); wait_idle();
    chk("R2 write addr byte", int'(ev_dat[0]), 8'h54);
    clr_log(); wr(0, 8'h6B); wr(2, 8'h05); wait_idle();
    chk("R3 held no start", int'(ev_cmd[0]), 1);
    chk("R3 held one phase", ev_n, 1);

    // Halt with interrupt
    wr(3, 8'h04); wr(6, 8'h08); clr_log();
    wr(2, 8'h80); wait_idle();
    chk("R7 halt stop", int'(ev_cmd[0]), 3);
    rd(5, v); chk("R7 bus freed", v, 8'h40);
    chk("R7 halt irq", int'(irq), 1);
    rd(4, v); chk("R7 status irq bit", (v >> 1) & 1, 1);
    wr(4, 8'h02);
    chk("R8 irq cleared", int'(irq), 0);
    rd(4, v); chk("R8 status bit1 cleared", (v >> 1) & 1, 0);

    // Read data ordering and empty buffer
    wr(3, 8'h40); clr_log(); wr(2, 8'h13); wait_idle();
    rd(0, v); chk("R5 rx byte0", v, 8'hA0);
    rd(0, v); chk("R5 rx byte1", v, 8'hA1);
    rd(0, v); chk("R5 empty reads FF", v, 8'hFF);
    rd(2, v); chk("R1 ctrl readback", v, 8'h12);

    // Completion interrupt gating
    wr(3, 8'h04); wr(6, 8'h01); wr(0, 8'h01); clr_log(); wr(2, 8'h01); wait_idle();
    chk("R6 done irq", int'(irq), 1);
    rd(4, v); chk("R6 status bit1", (v >> 1) & 1, 1);
    wr(4, 8'h02);
    wr(6, 8'h08); wr(0, 8'h01); wr(2, 8'h01); wait_idle();
    chk("R6 mask0 clear no irq", int'(irq), 0);
    wr(6, 8'h01); dev_addr = 7'h7F; wr(2, 8'h01); wait_idle();
    chk("R6 zero bytes no irq", int'(irq), 0);
    dev_addr = 7'h2A; wr(5, 8'h01);

    // Control without start
    clr_log(); wr(2, 8'h30);
    rd(2, v); chk("R1 no start stored", v, 8'h30);
    chk("R1 no start no phases", ev_n, 0);

    // Write masks and flush
    wr(0, 8'h77); wr(3, 8'hFF);
    rd(3, v); chk("R10 mode mask", v, 8'h3D);
    rd(0, v); chk("R10 flush empties", v, 8'hFF);
    wr(7, 8'hFF);
    rd(7, v); chk("R10 count mask", v, 8'h77);

    // Soft reset
    wr(6, 8'h0F); wr(0, 8'h99);
    wr(8, 8'h01);
    rd(1, v); chk("R11 addr kept", v, 8'h54);
    rd(3, v); chk("R11 mode cleared", v, 0);
    rd(6, v); chk("R11 mask cleared", v, 0);
    rd(7, v); chk("R11 count cleared", v, 0);
    rd(2, v); chk("R11 ctrl cleared", v, 0);
    rd(0, v); chk("R11 buffer cleared", v, 8'hFF);

    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule